// File: doc/BRIEF.md
# Five-Step Multi-Cycle Processor Datapath

This block executes one instruction at a time. Each instruction passes through five clocked steps: fetch, operand read, execute, memory and writeback. A step sequencer counts through the steps and drives every select and enable. Each step leaves its result in a staging register, and the next step reads only that register. Two staging registers hold the operands, one holds the ALU result, one holds the store data and one holds the writeback value. The register file has two read ports and one write port.

A single synchronous memory port serves both instruction fetch and data access. The address comes from the program counter in the fetch step. In the memory step of a load or store it comes from the ALU result register. Read data returns one cycle after the address is presented. A fetched word is therefore decoded straight from the port in step 2, and a loaded word is written straight from the port in step 5.

The block is intended as the core of a small controller. The writeback port is brought out so that a system can follow the architectural register state.

Top module: `mc_datapath`

## Requirements
- R1: After reset the step output reads 1. It then advances 1, 2, 3, 4, 5 and wraps to 1, so every instruction takes exactly five cycles.
- R2: In step 1 `mem_addr` equals the program counter, which starts at 0. The next instruction is fetched at PC+4 unless the instruction was a call. Instruction fields: opcode [31:26], rd [25:21], rs1 [20:16], rs2 [15:11], immediate [15:0].
- R3: Opcode 1 (add) writes rs1+rs2 into rd. The write is visible on the writeback port in step 5.
- R4: Opcode 2 (subtract) writes rs1−rs2 into rd. With source values 0x8765 and 0x4321, the value 0x4444 is written in the fifth cycle of the instruction.
- R5: Opcode 3 (add-immediate) writes rs1 plus the sign-extended 16-bit immediate into rd.
- R6: Opcode 4 (load) presents rs1+sext(imm) on `mem_addr` in step 4. The word returned in step 5 is written to rd.
- R7: Opcode 5 (store) raises `mem_we` in step 4, with address rs1+sext(imm) and data equal to the register named by the rd field. It writes no register.
- R8: Opcode 6 (call) writes the address of the following instruction into rd. The next fetch is at that address plus sext(imm)×4.
- R9: `wb_en` is high only in step 5, and only for opcodes 1, 2, 3, 4 and 6. Every other opcode writes neither a register nor memory.
- R10: Register 0 always reads as zero. A write to register 0 has no effect.
- R11: `mem_we` is high only in step 4, and only for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | XLEN | Shared memory byte address: fetch or data |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Read data, valid one cycle after the address |
| step | output | 3 | Current step number, 1 to 5 |
| wb_en | output | 1 | Register-file write in this cycle |
| wb_idx | output | 5 | Destination register of the write |
| wb_data | output | XLEN | Value being written |

## Verification
The case hardest to reach from the ports is a load that reads back a word written by an earlier store of the same program. It depends on the two uses of the shared port, and on the one-cycle read latency, lining up across separate instructions. Each program in the sweep first loads two operands, then computes with them, stores the results and loads one of them back. It also writes register 0 and reads it back, runs an opcode that decodes to nothing, and ends with a call that jumps over one word. This program is rerun for every pair drawn from a set of boundary operand values. A reference model in the bench predicts every step-1 fetch address, every step-4 memory access and every step-5 write.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

   localparam int ILEN = 32;

   localparam logic [5:0] OPC_ADD   = 6'd1;
   localparam logic [5:0] OPC_SUB   = 6'd2;
   localparam logic [5:0] OPC_ADDI  = 6'd3;
   localparam logic [5:0] OPC_LOAD  = 6'd4;
   localparam logic [5:0] OPC_STORE = 6'd5;
   localparam logic [5:0] OPC_CALL  = 6'd6;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd1,
      ST_DECODE = 3'd2,
      ST_EXEC   = 3'd3,
      ST_MEM    = 3'd4,
      ST_WB     = 3'd5
   } step_e;

   typedef enum logic { OPB_REG,  OPB_IMM  } opb_sel_e;
   typedef enum logic { RES_ALU,  RES_LINK } res_sel_e;
   typedef enum logic { ADR_PC,   ADR_DATA } adr_sel_e;
   typedef enum logic { ALU_ADD,  ALU_SUB  } alu_op_e;

   typedef struct packed {
      opb_sel_e opb;
      res_sel_e res;
      alu_op_e  alu;
      logic     wr_rd;
      logic     ld;
      logic     st;
      logic     call;
   } ctrl_t;

   function automatic ctrl_t decode_op(input logic [5:0] opc);
      ctrl_t c;
      c.opb   = OPB_REG;
      c.res   = RES_ALU;
      c.alu   = ALU_ADD;
      c.wr_rd = 1'b0;
      c.ld    = 1'b0;
      c.st    = 1'b0;
      c.call  = 1'b0;
      case (opc)
         OPC_ADD:   c.wr_rd = 1'b1;
         OPC_SUB: begin
            c.alu   = ALU_SUB;
            c.wr_rd = 1'b1;
         end
         OPC_ADDI: begin
            c.opb   = OPB_IMM;
            c.wr_rd = 1'b1;
         end
         OPC_LOAD: begin
            c.opb   = OPB_IMM;
            c.wr_rd = 1'b1;
            c.ld    = 1'b1;
         end
         OPC_STORE: begin
            c.opb = OPB_IMM;
            c.st  = 1'b1;
         end
         OPC_CALL: begin
            c.res   = RES_LINK;
            c.wr_rd = 1'b1;
            c.call  = 1'b1;
         end
         default: ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/mcd_regfile.sv
module mcd_regfile
#(
   parameter int XLEN      = 32,
   parameter int NREG      = 32,
   parameter bit HARD_ZERO = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(NREG)-1:0] ra_idx,
   output logic [XLEN-1:0]         ra_data,
   input  logic [$clog2(NREG)-1:0] rb_idx,
   output logic [XLEN-1:0]         rb_data,
   input  logic                    we,
   input  logic [$clog2(NREG)-1:0] w_idx,
   input  logic [XLEN-1:0]         w_data
);

   localparam int AW = $clog2(NREG);

   logic [XLEN-1:0] regs [NREG];
   logic            w_blocked;

   assign w_blocked = HARD_ZERO && (w_idx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we && !w_blocked) begin
         regs[w_idx] <= w_data;
      end
   end

   generate
      if (HARD_ZERO) begin : g_zero_reg
         assign ra_data = (ra_idx == AW'(0)) ? '0 : regs[ra_idx];
         assign rb_data = (rb_idx == AW'(0)) ? '0 : regs[rb_idx];

         AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (ra_idx == AW'(0)) |-> (ra_data == '0)); // R10
      end else begin : g_plain_reg
         assign ra_data = regs[ra_idx];
         assign rb_data = regs[rb_idx];
      end
   endgenerate

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (w_idx != AW'(0))) |=> (regs[$past(w_idx)] == $past(w_data))); // R3

endmodule

// File: rtl/mcd_alu.sv
module mcd_alu
   import mcd_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit SHARED_ADDER = 1'b1
)(
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y
);

   generate
      if (SHARED_ADDER) begin : g_one_adder
         logic sub;
         assign sub = (op == ALU_SUB);
         assign y   = a + (b ^ {XLEN{sub}}) + XLEN'(sub);
      end else begin : g_two_paths
         always_comb begin
            case (op)
               ALU_SUB: y = a - b;
               default: y = a + b;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/mcd_sequencer.sv
module mcd_sequencer
   import mcd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_rd,
   input  logic     ld,
   input  logic     st,
   output step_e    step,
   output logic     pc_en,
   output logic     opr_en,
   output logic     exe_en,
   output logic     res_en,
   output logic     rf_we,
   output logic     mem_we,
   output adr_sel_e adr_sel
);

   step_e step_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               step_q <= ST_FETCH;
      else if (step_q == ST_WB) step_q <= ST_FETCH;
      else                      step_q <= step_e'(step_q + 3'd1);
   end

   assign step    = step_q;
   assign pc_en   = (step_q == ST_FETCH);
   assign opr_en  = (step_q == ST_DECODE);
   assign exe_en  = (step_q == ST_EXEC);
   assign res_en  = (step_q == ST_MEM);
   assign rf_we   = (step_q == ST_WB) && wr_rd;
   assign mem_we  = (step_q == ST_MEM) && st;
   assign adr_sel = ((step_q == ST_MEM) && (ld || st)) ? ADR_DATA : ADR_PC;

   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_WB) |=> (step_q == ST_FETCH)); // R1

   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q != ST_WB) |=> (step_q == step_e'($past(step_q) + 3'd1))); // R1

   AST_ONE_STAGE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pc_en, opr_en, exe_en, res_en, rf_we})); // R1

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
   import mcd_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter int              NREG         = 32,
   parameter logic [XLEN-1:0] RESET_PC     = '0,
   parameter bit              HARD_ZERO    = 1'b1,
   parameter bit              SHARED_ADDER = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] mem_addr,
   output logic            mem_we,
   output logic [XLEN-1:0] mem_wdata,
   input  logic [XLEN-1:0] mem_rdata,
   output logic [2:0]      step,
   output logic            wb_en,
   output logic [4:0]      wb_idx,
   output logic [XLEN-1:0] wb_data
);

   localparam int              AW     = $clog2(NREG);
   localparam logic [XLEN-1:0] PC_INC = XLEN'(ILEN / 8);

   generate
      if (XLEN < ILEN) begin : g_bad_xlen
         $error("mc_datapath: XLEN must hold a whole instruction word");
      end
      if ((NREG < 2) || (NREG > 32) || ((1 << AW) != NREG)) begin : g_bad_nreg
         $error("mc_datapath: NREG must be a power of two from 2 to 32");
      end
   endgenerate

   // staging and architectural state
   logic [XLEN-1:0] pc_q, pc_tmp_q;
   logic [ILEN-1:0] ir_q;
   logic [XLEN-1:0] ra_q, rb_q, rz_q, rm_q, ry_q;

   // control
   step_e    step_q;
   ctrl_t    ctl;
   adr_sel_e adr_sel;
   logic     pc_en, opr_en, exe_en, res_en, rf_we, mem_we_i;

   // datapath nets
   logic [ILEN-1:0] fetched;
   logic            fetched_st;
   logic [AW-1:0]   rd_a_idx, rd_b_idx;
   logic [XLEN-1:0] rf_a, rf_b;
   logic [XLEN-1:0] imm_ext, alu_b, alu_y, ry_d, wb_val;

   assign ctl = decode_op(ir_q[31:26]);

   // operand read works on the word arriving from memory in step 2
   assign fetched    = mem_rdata[ILEN-1:0];
   assign fetched_st = (fetched[31:26] == OPC_STORE);
   assign rd_a_idx   = fetched[16 +: AW];
   assign rd_b_idx   = fetched_st ? fetched[21 +: AW] : fetched[11 +: AW];

   mcd_sequencer u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_rd   (ctl.wr_rd),
      .ld      (ctl.ld),
      .st      (ctl.st),
      .step    (step_q),
      .pc_en   (pc_en),
      .opr_en  (opr_en),
      .exe_en  (exe_en),
      .res_en  (res_en),
      .rf_we   (rf_we),
      .mem_we  (mem_we_i),
      .adr_sel (adr_sel)
   );

   mcd_regfile #(
      .XLEN      (XLEN),
      .NREG      (NREG),
      .HARD_ZERO (HARD_ZERO)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_idx  (rd_a_idx),
      .ra_data (rf_a),
      .rb_idx  (rd_b_idx),
      .rb_data (rf_b),
      .we      (rf_we),
      .w_idx   (ir_q[21 +: AW]),
      .w_data  (wb_val)
   );

   assign imm_ext = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
   assign alu_b   = (ctl.opb == OPB_IMM) ? imm_ext : rb_q;

   mcd_alu #(
      .XLEN         (XLEN),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_alu (
      .a  (ra_q),
      .b  (alu_b),
      .op (ctl.alu),
      .y  (alu_y)
   );

   assign ry_d   = (ctl.res == RES_LINK) ? pc_tmp_q : rz_q;
   assign wb_val = ctl.ld ? mem_rdata : ry_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q     <= RESET_PC;
         pc_tmp_q <= '0;
         ir_q     <= '0;
         ra_q     <= '0;
         rb_q     <= '0;
         rz_q     <= '0;
         rm_q     <= '0;
         ry_q     <= '0;
      end else begin
         if (pc_en) begin
            pc_q     <= pc_q + PC_INC;
            pc_tmp_q <= pc_q + PC_INC;
         end else if (exe_en && ctl.call) begin
            pc_q <= pc_q + (imm_ext << 2);
         end
         if (opr_en) begin
            ir_q <= fetched;
            ra_q <= rf_a;
            rb_q <= rf_b;
         end
         if (exe_en) begin
            rz_q <= alu_y;
            rm_q <= rb_q;
         end
         if (res_en) ry_q <= ry_d;
      end
   end

   assign mem_addr  = (adr_sel == ADR_DATA) ? rz_q : pc_q;
   assign mem_we    = mem_we_i;
   assign mem_wdata = rm_q;
   assign step      = step_q;
   assign wb_en     = rf_we;
   assign wb_idx    = ir_q[25:21];
   assign wb_data   = wb_val;

   AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q == ST_FETCH) |=> (pc_q == $past(pc_q) + PC_INC)); // R2

   AST_IR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q != ST_DECODE) |=> $stable(ir_q)); // R2

   AST_STORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_wdata == $past(rb_q))); // R7

   AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ((step_q == ST_MEM) && ctl.ld) |-> (mem_addr == $past(alu_y))); // R6

   AST_MEMWE_IN_STEP4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (step_q == ST_MEM)); // R11

   AST_WB_IN_STEP5: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (step_q == ST_WB)); // R9

endmodule

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, wb_data;
   logic        mem_we, wb_en;
   logic [2:0]  step;
   logic [4:0]  wb_idx;

   int checks = 0;
   int errors = 0;

   logic [31:0] mem [64];
   logic [31:0] mm  [64];
   logic [31:0] m   [32];

   always #(CLK_PERIOD/2) clk = ~clk;

   mc_datapath dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .step      (step),
      .wb_en     (wb_en),
      .wb_idx    (wb_idx),
      .wb_data   (wb_data)
   );

   // synchronous memory, one cycle of read latency
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:2]];
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input logic [5:0] op, input int rd,
                                         input int rs1, input int rs2);
      return {op, 5'(rd), 5'(rs1), 5'(rs2), 11'd0};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rd,
                                         input int rs1, input logic [15:0] imm);
      return {op, 5'(rd), 5'(rs1), imm};
   endfunction

   function automatic logic [31:0] rv(input int i);
      return (i == 0) ? 32'd0 : m[i];
   endfunction

   task automatic put(input int idx, input logic [31:0] w);
      mem[idx] = w;
      mm[idx]  = w;
   endtask

   task automatic load_prog(input logic [31:0] va, input logic [31:0] vb);
      for (int i = 0; i < 64; i++) put(i, 32'd0);
      put(0,  enc_i(6'd4, 1, 0, 16'h0080));        // load r1
      put(1,  enc_i(6'd4, 2, 0, 16'h0084));        // load r2
      put(2,  enc_r(6'd1, 3, 1, 2));               // add
      put(3,  enc_r(6'd2, 4, 1, 2));               // subtract
      put(4,  enc_i(6'd3, 5, 1, vb[15:0]));        // add-immediate
      put(5,  enc_i(6'd5, 3, 0, 16'h0088));        // store r3
      put(6,  enc_i(6'd5, 4, 0, 16'h008C));        // store r4
      put(7,  enc_i(6'd4, 6, 0, 16'h0088));        // load back
      put(8,  enc_i(6'd3, 0, 1, 16'h0005));        // write r0
      put(9,  enc_r(6'd1, 7, 0, 2));               // read r0
      put(10, enc_i(6'd9, 10, 1, 16'h0088));       // undefined opcode
      put(11, enc_i(6'd6, 31, 0, 16'h0001));       // call, skips word 12
      put(12, enc_i(6'd3, 8, 0, 16'h0001));
      put(13, enc_r(6'd1, 9, 31, 0));
      put(32, va);
      put(33, vb);
   endtask

   task automatic exec_one(inout logic [31:0] pc);
      logic [31:0] w, simm, ea, res, npc;
      logic [5:0]  op;
      int          rd, rs1, rs2;
      logic        writes;
      string       tag;
      w    = mm[pc[7:2]];
      op   = w[31:26];
      rd   = int'(w[25:21]);
      rs1  = int'(w[20:16]);
      rs2  = int'(w[15:11]);
      simm = {{16{w[15]}}, w[15:0]};
      ea   = rv(rs1) + simm;
      npc  = pc + 32'd4;
      writes = (op == 6'd1) || (op == 6'd2) || (op == 6'd3) ||
               (op == 6'd4) || (op == 6'd6);
      res  = 32'd0;
      tag  = "R9";
      case (op)
         6'd1: begin res = rv(rs1) + rv(rs2); tag = (rs1 == 0) ? "R10" : "R3"; end
         6'd2: begin res = rv(rs1) - rv(rs2); tag = "R4"; end
         6'd3: begin res = ea;                tag = "R5"; end
         6'd4: begin res = mm[ea[7:2]];       tag = "R6"; end
         6'd6: begin res = pc + 32'd4; npc = pc + 32'd4 + (simm << 2); tag = "R8"; end
         default: ;
      endcase
      // step 1
      chk("R1", "step", {29'd0, step}, 32'd1);
      chk("R2", "fetch address", mem_addr, pc);
      chk("R11", "we in fetch", {31'd0, mem_we}, 32'd0);
      @(negedge clk);
      chk("R1", "step", {29'd0, step}, 32'd2);
      chk("R9", "wb in step 2", {31'd0, wb_en}, 32'd0);
      @(negedge clk);
      chk("R1", "step", {29'd0, step}, 32'd3);
      @(negedge clk);
      chk("R1", "step", {29'd0, step}, 32'd4);
      chk("R9", "wb in step 4", {31'd0, wb_en}, 32'd0);
      if (op == 6'd5) begin
         chk("R7", "store strobe", {31'd0, mem_we}, 32'd1);
         chk("R7", "store address", mem_addr, ea);
         chk("R7", "store data", mem_wdata, rv(rd));
         mm[ea[7:2]] = rv(rd);
      end else begin
         chk("R11", "no write strobe", {31'd0, mem_we}, 32'd0);
      end
      if (op == 6'd4) chk("R6", "load address", mem_addr, ea);
      @(negedge clk);
      chk("R1", "step", {29'd0, step}, 32'd5);
      chk("R9", "write enable", {31'd0, wb_en}, {31'd0, writes});
      chk("R11", "we in writeback", {31'd0, mem_we}, 32'd0);
      if (writes) begin
         chk(tag, "dest index", {27'd0, wb_idx}, rd);
         chk(tag, "write value", wb_data, res);
         if (rd != 0) m[rd] = res;
      end
      @(negedge clk);
      pc = npc;
   endtask

   task automatic run_combo(input logic [31:0] va, input logic [31:0] vb);
      logic [31:0] pc;
      rst_n = 1'b0;
      load_prog(va, vb);
      for (int i = 0; i < 32; i++) m[i] = 32'd0;
      repeat (2) @(negedge clk);
      chk("R1", "reset step", {29'd0, step}, 32'd1);
      chk("R1", "reset address", mem_addr, 32'd0);
      chk("R1", "reset we", {31'd0, mem_we}, 32'd0);
      chk("R1", "reset wb", {31'd0, wb_en}, 32'd0);
      rst_n = 1'b1;
      pc = 32'd0;
      for (int k = 0; k < 13; k++) exec_one(pc);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] vals [8];
      vals[0] = 32'h0000_8765; vals[1] = 32'h0000_4321;
      vals[2] = 32'h0000_0000; vals[3] = 32'h0000_0001;
      vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h8000_0000;
      vals[6] = 32'hFFFF_FFFF; vals[7] = 32'h1234_F678;
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            run_combo(vals[a], vals[b]);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule